// File: doc/BRIEF.md
# Event Performance Monitor

This block counts activity inside a processor subsystem. A cycle counter and four programmable 32-bit event counters are reached through a small register port: a write strobe, a word address, write data and a read-data bus that follows the address with no wait. A control word sets the global run state and the prescaler mode. The same word carries two write-one strobes, one that zeroes every event counter and one that zeroes the cycle counter together with its prescaler.

Each event counter watches one of twelve event codes. Code 0 is the software-increment source, driven by writes to a dedicated register. Codes 1 to 11 each come from one bit of an external pulse bus. Software picks a counter by writing its index to a select register, then reads or writes that counter's event code and count through two windowed addresses. Counters start only when their own bit in a set-only enable register is on. A wrap from all ones to zero latches a sticky overflow flag, which software clears by writing one to it.

Top module: `perf_monitor`

## Requirements
- R1: After reset all readable registers hold zero, except the capability register at address 7, which reads 0x00000FFF.
- R2: While control bit 0 (run) is clear, neither the cycle counter nor any event counter changes, except through a direct write.
- R3: A write with control bit 1 set zeroes all four event counters. A write with control bit 2 set zeroes the cycle counter and its prescaler. Bits 1 and 2 always read back as 0.
- R4: With control bit 3 clear the cycle counter advances every clock. With it set the counter advances exactly once per 64 clocks.
- R5: Writing a value of 0 to 3 to the select register (address 3) selects that counter. Writing any value of 4 or more leaves the selection unchanged.
- R6: An enabled event counter whose code is c, for c from 1 to 11, advances once for each clock in which evt_in[c] is high.
- R7: An enabled event counter whose code is 0 advances once for each write to address 8 that has the counter's bit (bits 0 to 3) set.
- R8: Writing to the enable register (address 1) sets every bit written as 1 and leaves bits written as 0 unchanged. Bits 0 to 3 enable the event counters and bit 31 enables the cycle counter.
- R9: A wrap from 0xFFFFFFFF to 0 sets the counter's overflow bit at address 2 (bits 0 to 3 for the event counters, bit 31 for the cycle counter). Writing 1 to a bit clears it. A wrap in the same cycle as a clear leaves the bit set.
- R10: The capability register (address 7) reads 0x00000FFF, one bit for each implemented code, and ignores writes.
- R11: An event counter programmed with a code of 0x0C or above never advances.
- R12: Writing address 5 loads the selected counter's count, writing address 4 loads its event code, and writing address 6 loads the cycle counter. Reads at the same addresses return those values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 4 | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_in | input | 12 | Event pulses; bit c serves code c (bit 0 unused) |

## Verification
A wrong select index shows up at once as the wrong count or code at addresses 4 and 5. A wrong enable, code or prescaler state shows up as a count difference that grows each cycle, or each 64 cycles in divided mode, and the bench reads it after known pulse trains and windows of known length. A missed or spurious overflow flag is visible at address 2 in the cycle after the wrap. The bench drives a wrap in the same cycle as a clear, which exposes a clear that wrongly wins.

// File: rtl/pmon_pkg.sv
// Package: pmon_pkg
// Shared sizes, register addresses and control-bit positions for the
// performance monitor. Assumes a 32-bit register data path.
package pmon_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int NUM_CNT   = 4;
    localparam int NUM_CODES = 12;
    localparam int TYPE_W    = 8;
    localparam int PRESCALE  = 64;
    localparam int CYC_BIT   = 31;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_CNTEN = 4'd1;
    localparam logic [ADDR_W-1:0] A_OVF   = 4'd2;
    localparam logic [ADDR_W-1:0] A_SEL   = 4'd3;
    localparam logic [ADDR_W-1:0] A_TYPE  = 4'd4;
    localparam logic [ADDR_W-1:0] A_COUNT = 4'd5;
    localparam logic [ADDR_W-1:0] A_CYC   = 4'd6;
    localparam logic [ADDR_W-1:0] A_CAPS  = 4'd7;
    localparam logic [ADDR_W-1:0] A_SWINC = 4'd8;

    localparam int CTL_RUN   = 0;
    localparam int CTL_EVRST = 1;
    localparam int CTL_CYRST = 2;
    localparam int CTL_DIV   = 3;
endpackage

// File: rtl/pmon_event_counter.sv
// Module: pmon_event_counter
// One programmable event counter. It holds an event code and a count. The
// count advances when the counter runs and its code's source fires: code 0
// uses the software increment strobe, codes 1..NUM_CODES-1 use evt_in.
// Codes at or above NUM_CODES never advance. Assumes clear and load are
// never requested in the same cycle.
module pmon_event_counter #(
    parameter int DATA_W    = 32,
    parameter int TYPE_W    = 8,
    parameter int NUM_CODES = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 clear,
    input  logic                 type_we,
    input  logic                 count_we,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_CODES-1:0] evt_in,
    input  logic                 swinc,
    output logic [TYPE_W-1:0]    type_q,
    output logic [DATA_W-1:0]    count_q,
    output logic                 wrap
);
    logic hit;
    logic inc;

    // Select the pulse source named by the programmed code.
    always_comb begin
        hit = 1'b0;
        if (type_q == '0) begin
            hit = swinc;
        end
        for (int c = 1; c < NUM_CODES; c++) begin
            if (type_q == TYPE_W'(c)) begin
                hit = evt_in[c];
            end
        end
    end

    assign inc  = run && hit && !count_we && !clear;
    assign wrap = inc && (&count_q);

    // Hold the event code written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q <= '0;
        end else if (type_we) begin
            type_q <= wdata[TYPE_W-1:0];
        end
    end

    // Count: clear, then load, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (count_we) begin
            count_q <= wdata;
        end else if (inc) begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/pmon_cycle_counter.sv
// Module: pmon_cycle_counter
// Cycle counter with an optional divide-by-PRESCALE prescaler. The
// prescaler runs only while the counter runs in divided mode, and clear
// zeroes both. Assumes PRESCALE is at least 2.
module pmon_cycle_counter #(
    parameter int DATA_W   = 32,
    parameter int PRESCALE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              div_en,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count_q,
    output logic              wrap
);
    localparam int PRE_W = $clog2(PRESCALE);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0] pre_q;
    logic             tick;
    logic             inc;

    assign tick = run && (!div_en || (pre_q == PRE_LAST));
    assign inc  = tick && !load && !clear;
    assign wrap = inc && (&count_q);

    // Prescaler: counts clocks while running in divided mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clear) begin
            pre_q <= '0;
        end else if (run && div_en) begin
            pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
        end
    end

    // Cycle count: clear, then load, then tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= wdata;
        end else if (inc) begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/pmon_flag_bank.sv
// Module: pmon_flag_bank
// Holds the set-only count-enable bits and the sticky overflow bits. Only
// the bits in IMPL_MASK exist; the others read as zero. A wrap in the same
// cycle as a write-one clear keeps the overflow bit set.
module pmon_flag_bank #(
    parameter int               WIDTH     = 32,
    parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set_we,
    input  logic             ovf_clr_we,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] wrap_vec,
    output logic [WIDTH-1:0] cnten_q,
    output logic [WIDTH-1:0] ovf_q
);
    logic [WIDTH-1:0] set_mask;
    logic [WIDTH-1:0] clr_mask;

    assign set_mask = en_set_we  ? (wdata & IMPL_MASK) : '0;
    assign clr_mask = ovf_clr_we ? wdata : '0;

    // Enable bits: set by writing ones, never cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnten_q <= '0;
        end else begin
            cnten_q <= cnten_q | set_mask;
        end
    end

    // Overflow bits: set by a wrap, cleared by writing one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= '0;
        end else begin
            ovf_q <= ((ovf_q & ~clr_mask) | wrap_vec) & IMPL_MASK;
        end
    end
endmodule

// File: rtl/perf_monitor.sv
// Module: perf_monitor
// Top level of the performance monitor. Decodes the register port, holds
// the control word and the counter selection, and routes the windowed code
// and count accesses to the selected event counter. Assumes one register
// write per cycle; reads are combinational on reg_addr.
module perf_monitor
    import pmon_pkg::*;
#(
    parameter int N_CNT  = pmon_pkg::NUM_CNT,
    parameter int N_CODE = pmon_pkg::NUM_CODES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_CODE-1:0] evt_in
);
    localparam int SEL_W = (N_CNT > 1) ? $clog2(N_CNT) : 1;
    localparam logic [DATA_W-1:0] CAPS_VAL  = DATA_W'((64'd1 << N_CODE) - 64'd1);
    localparam logic [DATA_W-1:0] EVT_MASK  = DATA_W'((64'd1 << N_CNT) - 64'd1);
    localparam logic [DATA_W-1:0] IMPL_MASK = EVT_MASK | (DATA_W'(1) << CYC_BIT);

    logic                          run_q;
    logic                          div_q;
    logic [SEL_W-1:0]              sel_q;
    logic                          ctrl_we;
    logic                          evt_clr;
    logic                          cyc_clr;
    logic [N_CNT-1:0]              swinc_vec;
    logic [DATA_W-1:0]             cnten_q;
    logic [DATA_W-1:0]             ovf_q;
    logic [DATA_W-1:0]             wrap_vec;
    logic [N_CNT-1:0]              evt_wrap;
    logic                          cyc_wrap;
    logic [DATA_W-1:0]             cyc_q;
    logic [N_CNT-1:0][DATA_W-1:0]  cnt_arr;
    logic [N_CNT-1:0][TYPE_W-1:0]  type_arr;

    assign ctrl_we   = reg_we && (reg_addr == A_CTRL);
    assign evt_clr   = ctrl_we && reg_wdata[CTL_EVRST];
    assign cyc_clr   = ctrl_we && reg_wdata[CTL_CYRST];
    assign swinc_vec = (reg_we && (reg_addr == A_SWINC)) ? reg_wdata[N_CNT-1:0] : '0;

    // Control word: run and divide bits; the reset bits are strobes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            div_q <= 1'b0;
        end else if (ctrl_we) begin
            run_q <= reg_wdata[CTL_RUN];
            div_q <= reg_wdata[CTL_DIV];
        end
    end

    // Counter selection: out-of-range indices are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (reg_we && (reg_addr == A_SEL) && (reg_wdata < DATA_W'(N_CNT))) begin
            sel_q <= reg_wdata[SEL_W-1:0];
        end
    end

    // One event counter per index.
    for (genvar i = 0; i < N_CNT; i++) begin : g_evt
        logic hit_sel;
        assign hit_sel = (sel_q == SEL_W'(i));
        pmon_event_counter #(
            .DATA_W    (DATA_W),
            .TYPE_W    (TYPE_W),
            .NUM_CODES (N_CODE)
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_q && cnten_q[i]),
            .clear    (evt_clr),
            .type_we  (reg_we && (reg_addr == A_TYPE) && hit_sel),
            .count_we (reg_we && (reg_addr == A_COUNT) && hit_sel),
            .wdata    (reg_wdata),
            .evt_in   (evt_in),
            .swinc    (swinc_vec[i]),
            .type_q   (type_arr[i]),
            .count_q  (cnt_arr[i]),
            .wrap     (evt_wrap[i])
        );
    end

    pmon_cycle_counter #(
        .DATA_W   (DATA_W),
        .PRESCALE (PRESCALE)
    ) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q && cnten_q[CYC_BIT]),
        .div_en  (div_q),
        .clear   (cyc_clr),
        .load    (reg_we && (reg_addr == A_CYC)),
        .wdata   (reg_wdata),
        .count_q (cyc_q),
        .wrap    (cyc_wrap)
    );

    // Gather wrap pulses into the status bit layout.
    always_comb begin
        wrap_vec              = '0;
        wrap_vec[N_CNT-1:0]   = evt_wrap;
        wrap_vec[CYC_BIT]     = cyc_wrap;
    end

    pmon_flag_bank #(
        .WIDTH     (DATA_W),
        .IMPL_MASK (IMPL_MASK)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_set_we  (reg_we && (reg_addr == A_CNTEN)),
        .ovf_clr_we (reg_we && (reg_addr == A_OVF)),
        .wdata      (reg_wdata),
        .wrap_vec   (wrap_vec),
        .cnten_q    (cnten_q),
        .ovf_q      (ovf_q)
    );

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[CTL_RUN] = run_q;
                reg_rdata[CTL_DIV] = div_q;
            end
            A_CNTEN: reg_rdata = cnten_q;
            A_OVF:   reg_rdata = ovf_q;
            A_SEL:   reg_rdata = DATA_W'(sel_q);
            A_TYPE:  reg_rdata = DATA_W'(type_arr[sel_q]);
            A_COUNT: reg_rdata = cnt_arr[sel_q];
            A_CYC:   reg_rdata = cyc_q;
            A_CAPS:  reg_rdata = CAPS_VAL;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pmon_checker.sv
// Module: pmon_checker
// Property checks for perf_monitor, attached by bind. Observes the port
// and the held state; drives nothing.
module pmon_checker
    import pmon_pkg::*;
#(
    parameter int N_CNT = pmon_pkg::NUM_CNT,
    parameter int SEL_W = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         reg_we,
    input logic [ADDR_W-1:0]            reg_addr,
    input logic [DATA_W-1:0]            reg_wdata,
    input logic [DATA_W-1:0]            reg_rdata,
    input logic                         run_q,
    input logic [SEL_W-1:0]             sel_q,
    input logic [DATA_W-1:0]            cnten_q,
    input logic [DATA_W-1:0]            ovf_q,
    input logic [DATA_W-1:0]            cyc_q,
    input logic [N_CNT-1:0][DATA_W-1:0] cnt_arr
);
    // R2
    idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !reg_we) |=> ($stable(cyc_q) && $stable(cnt_arr)));

    // R3
    strobe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CTRL) |-> (reg_rdata[CTL_CYRST:CTL_EVRST] == 2'b00));

    // R5
    bad_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == A_SEL) && (reg_wdata >= DATA_W'(N_CNT))) |=> $stable(sel_q));

    // R8
    enable_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnten_q & $past(cnten_q)) == $past(cnten_q)));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && (reg_addr == A_OVF)) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

    // R10
    caps_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CAPS) |-> (reg_rdata == 32'h0000_0FFF));
endmodule

bind perf_monitor pmon_checker #(
    .N_CNT (N_CNT),
    .SEL_W (SEL_W)
) u_pmon_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .run_q     (run_q),
    .sel_q     (sel_q),
    .cnten_q   (cnten_q),
    .ovf_q     (ovf_q),
    .cyc_q     (cyc_q),
    .cnt_arr   (cnt_arr)
);

// File: tb/test_perf_monitor.sv
`timescale 1ns/1ps
module test_perf_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [11:0] evt_in = 12'd0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    perf_monitor i_perf_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_in    (evt_in)
    );

    localparam logic [3:0] CTRL = 0, CNTEN = 1, OVF = 2, SEL = 3, TYP = 4,
                           CNT = 5, CYC = 6, CAPS = 7, SWINC = 8;

    typedef struct packed {
        logic        is_wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, CTRL,  32'h0,          8'd1},  // R1 control clear
        '{1'b0, CAPS,  32'h0000_0FFF,  8'd1},  // R1 caps
        '{1'b0, CNTEN, 32'h0,          8'd1},  // R1
        '{1'b0, OVF,   32'h0,          8'd1},  // R1
        '{1'b0, CYC,   32'h0,          8'd1},  // R1
        '{1'b1, SEL,   32'd2,          8'd5},  // R5 select 2
        '{1'b0, SEL,   32'd2,          8'd5},
        '{1'b1, SEL,   32'd5,          8'd5},  // R5 out of range
        '{1'b0, SEL,   32'd2,          8'd5},
        '{1'b1, TYP,   32'd3,          8'd12}, // R12 code load
        '{1'b0, TYP,   32'd3,          8'd12},
        '{1'b1, CNT,   32'h1234,       8'd12}, // R12 count load
        '{1'b0, CNT,   32'h1234,       8'd12},
        '{1'b1, CAPS,  32'h0,          8'd10}, // R10 write ignored
        '{1'b0, CAPS,  32'h0000_0FFF,  8'd10},
        '{1'b1, CNTEN, 32'h8000_0004,  8'd8},  // R8 set bits
        '{1'b1, CNTEN, 32'h0,          8'd8},  // R8 zeros keep
        '{1'b0, CNTEN, 32'h8000_0004,  8'd8},
        '{1'b1, CTRL,  32'h6,          8'd3},  // R3 strobes
        '{1'b0, CNT,   32'h0,          8'd3}   // R3 counter 2 cleared
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic pulse(input logic [11:0] m);
        @(negedge clk);
        evt_in = m;
        @(negedge clk);
        evt_in = 12'd0;
    endtask

    task automatic rd_cnt(input logic [31:0] idx, output logic [31:0] v);
        wr(SEL, idx);
        rd(CNT, v);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk
        for (int k = 0; k < NV; k++) begin
            if (VECS[k].is_wr) begin
                wr(VECS[k].addr, VECS[k].data);
            end else begin
                rd(VECS[k].addr, v);
                check($sformatf("R%0d vec%0d", VECS[k].req, k), v, VECS[k].data);
            end
        end

        // R2: stopped monitor ignores events and clocks
        pulse(12'h008);
        pulse(12'h008);
        rd(CNT, v);
        check("R2 event count frozen", v, 32'd0);
        rd(CYC, v);
        repeat (10) @(negedge clk);
        #0.5 v2 = reg_rdata;
        check("R2 cycle frozen", v2, v);

        // R4: undivided cycle counting
        wr(CTRL, 32'h1);
        rd(CYC, v);
        repeat (10) @(negedge clk);
        #0.5 v2 = reg_rdata;
        check("R4 undivided delta", v2 - v, 32'd10);

        // R6: coded event counting
        wr(SEL, 32'd1);
        wr(TYP, 32'd8);
        wr(CNTEN, 32'h2);
        for (int p = 0; p < 5; p++) pulse(12'h100);
        pulse(12'h008);
        pulse(12'h008);
        pulse(12'h020);
        rd_cnt(32'd1, v);
        check("R6 code 8 count", v, 32'd5);
        rd_cnt(32'd2, v);
        check("R6 code 3 count", v, 32'd2);

        // R7: software increment
        wr(SEL, 32'd0);
        wr(TYP, 32'd0);
        wr(CNTEN, 32'h1);
        for (int p = 0; p < 3; p++) wr(SWINC, 32'h3);
        rd_cnt(32'd0, v);
        check("R7 swinc count", v, 32'd3);
        rd_cnt(32'd1, v);
        check("R7 swinc ignored by code 8", v, 32'd5);

        // R11: unimplemented code
        wr(SEL, 32'd3);
        wr(TYP, 32'h0C);
        wr(CNTEN, 32'h8);
        for (int p = 0; p < 3; p++) pulse(12'hFFF);
        rd_cnt(32'd3, v);
        check("R11 code 0x0C frozen", v, 32'd0);
        rd_cnt(32'd1, v);
        check("R6 all-pulse count", v, 32'd8);

        // R9: overflow set, clear, and set winning over clear
        wr(SEL, 32'd1);
        wr(CNT, 32'hFFFF_FFFF);
        pulse(12'h100);
        rd(CNT, v);
        check("R9 wrap to zero", v, 32'd0);
        rd(OVF, v);
        check("R9 overflow set", v & 32'hF, 32'h2);
        wr(OVF, 32'h2);
        rd(OVF, v);
        check("R9 overflow cleared", v & 32'hF, 32'h0);
        wr(CNT, 32'hFFFF_FFFF);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = OVF; reg_wdata = 32'h2; evt_in = 12'h100;
        @(negedge clk);
        reg_we = 1'b0; evt_in = 12'd0;
        rd(OVF, v);
        check("R9 set beats clear", v & 32'hF, 32'h2);
        wr(CYC, 32'hFFFF_FFF0);
        repeat (20) @(negedge clk);
        rd(OVF, v);
        check("R9 cycle overflow bit 31", v & 32'h8000_0000, 32'h8000_0000);

        // R4: divide by 64, R3 strobe read-back
        wr(CTRL, 32'hD);
        rd(CYC, v);
        repeat (128) @(negedge clk);
        #0.5 v2 = reg_rdata;
        check("R4 divided delta", v2 - v, 32'd2);
        rd(CTRL, v);
        check("R3 control read-back", v, 32'h9);

        // R3: event reset while running
        wr(CTRL, 32'h3);
        rd_cnt(32'd1, v);
        check("R3 counter 1 cleared", v, 32'd0);
        rd_cnt(32'd0, v);
        check("R3 counter 0 cleared", v, 32'd0);

        // R2: stop again
        wr(CTRL, 32'h0);
        rd(CYC, v);
        repeat (20) @(negedge clk);
        #0.5 v2 = reg_rdata;
        check("R2 cycle stops", v2, v);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule